// File: doc/BRIEF.md
# Transfer Completion Event and Interrupt Logic

This block takes completion reports coming back from one or more DMA transfer controllers and turns them into chained-event triggers and a CPU interrupt. Each report names a 6-bit completion code, says whether the transfer request it closes was the final one of its parameter set or an intermediate one, and carries four enable bits. Two of the enables govern chaining and two govern interrupts. In each pair, one applies to the final request and the other to every request before it. A normal completion, an early completion and a dummy or null completion all arrive on the same report port and are handled the same way.

The code picks one of 64 bits. A chaining action sets that bit in a 64-bit chain event register and, in the following cycle, pulses the trigger line of the channel with that number. An interrupt action sets that bit in a 64-bit pending register. The interrupt line is high while any pending bit is also set in the interrupt mask. Software clears bits in either register by writing ones to a clear port. A hardware set takes priority over a clear of the same bit in the same cycle.

Each report port is a valid/ready stream. The block never applies back-pressure: ready rises one cycle after reset is released and stays high. A report is taken on every rising clock edge where valid and ready are both high. Valid may be held without waiting for ready, and reports sent before ready is high are lost.

Top module: `xfer_done_events`

## Requirements
- R1: A report with final=1 and the final-chain enable (cmpl_en bit 0) set sets chain_evt[code]. An intermediate report (final=0) with only bit 0 set changes nothing.
- R2: A report with final=1 and the final-interrupt enable (cmpl_en bit 2) set sets pend[code]. An intermediate report with only bit 2 set changes nothing.
- R3: A report with final=0 sets chain_evt[code] when the intermediate-chain enable (cmpl_en bit 1) is set, and sets pend[code] when the intermediate-interrupt enable (cmpl_en bit 3) is set. A final report with only bits 1 and 3 set changes nothing.
- R4: When both enables of one kind are set (bits 0 and 1, or bits 2 and 3), every report of a set, final or intermediate, performs that action.
- R5: Reports taken on different ports in the same cycle each set their own bit, so no update is lost. Two ports naming the same code set that single bit.
- R6: Writing clr_pend_bits with clr_pend_we=1 clears each pending bit written as 1 and leaves bits written as 0 unchanged. clr_chain_bits with clr_chain_we=1 acts the same way on chain_evt.
- R7: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: irq is high exactly when pend AND irq_mask is nonzero. It follows a change of irq_mask within the same cycle.
- R9: A chaining action on code n drives chain_trig[n] high for exactly the one cycle after the report is taken.
- R10: Reset clears chain_evt, pend and chain_trig. cmpl_ready is low during reset and high on every port from the first clock edge after release.
- R11: A report presented with cmpl_valid=0 has no effect, even with all enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | NUM_PORTS | Report valid, one per port |
| cmpl_ready | output | NUM_PORTS | Report ready, one per port |
| cmpl_code | input | NUM_PORTS x CODE_W | Completion code per port |
| cmpl_final | input | NUM_PORTS | 1 = final request of the set, 0 = intermediate |
| cmpl_en | input | NUM_PORTS x 4 | Enables: bit0 final chain, bit1 intermediate chain, bit2 final interrupt, bit3 intermediate interrupt |
| clr_chain_we | input | 1 | Strobe for clearing chain_evt |
| clr_chain_bits | input | 2^CODE_W | Chain bits to clear (write 1 to clear) |
| clr_pend_we | input | 1 | Strobe for clearing pend |
| clr_pend_bits | input | 2^CODE_W | Pending bits to clear (write 1 to clear) |
| irq_mask | input | 2^CODE_W | Interrupt enable per pending bit |
| chain_evt | output | 2^CODE_W | Chain event register |
| pend | output | 2^CODE_W | Interrupt pending register |
| chain_trig | output | 2^CODE_W | One-cycle chained-event triggers per channel |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that reports only arrive after ready has risen. They also assume that code, final and enables are stable, known values whenever valid is high. The bench drives every input at the falling edge, raises valid only after ready is observed high, and keeps valid low during and right after reset. Clears are driven only as single-cycle strobes, so each check at the next falling edge sees exactly one update.

// File: rtl/xfer_done_pkg.sv
package xfer_done_pkg;
  // Enable bits carried with each completion report (MSB first).
  typedef struct packed {
    logic irq_inter;
    logic irq_final;
    logic chain_inter;
    logic chain_final;
  } done_en_t;

  localparam int EN_W = $bits(done_en_t);
endpackage

// File: rtl/xfer_done_decode.sv
// Turns one completion report into chain/interrupt set vectors.
module xfer_done_decode
  import xfer_done_pkg::*;
#(
  parameter int CODE_W = 6,
  localparam int NCODE = 1 << CODE_W
) (
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic              is_final,
  input  done_en_t          en,
  output logic [NCODE-1:0]  chain_set,
  output logic [NCODE-1:0]  irq_set
);
  logic [NCODE-1:0] onehot;
  logic             do_chain;
  logic             do_irq;

  always_comb begin
    onehot   = {{(NCODE-1){1'b0}}, 1'b1} << code;
    do_chain = is_final ? en.chain_final : en.chain_inter;
    do_irq   = is_final ? en.irq_final   : en.irq_inter;
    chain_set = (take && do_chain) ? onehot : '0;
    irq_set   = (take && do_irq)   ? onehot : '0;
  end
endmodule

// File: rtl/xfer_done_bitreg.sv
// Sticky bit register: hardware set dominates write-one-to-clear.
module xfer_done_bitreg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_eff) | set_bits;
  end
endmodule

// File: rtl/xfer_done_pulse.sv
// Registers chain set events into one-cycle per-channel triggers.
module xfer_done_pulse #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] trig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= '0;
    else        trig <= set_bits;
  end
endmodule

// File: rtl/xfer_done_events.sv
module xfer_done_events
  import xfer_done_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int CODE_W    = 6,
  localparam int NCODE    = 1 << CODE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             cmpl_valid,
  output logic [NUM_PORTS-1:0]             cmpl_ready,
  input  logic [NUM_PORTS-1:0][CODE_W-1:0] cmpl_code,
  input  logic [NUM_PORTS-1:0]             cmpl_final,
  input  logic [NUM_PORTS-1:0][EN_W-1:0]   cmpl_en,
  input  logic                             clr_chain_we,
  input  logic [NCODE-1:0]                 clr_chain_bits,
  input  logic                             clr_pend_we,
  input  logic [NCODE-1:0]                 clr_pend_bits,
  input  logic [NCODE-1:0]                 irq_mask,
  output logic [NCODE-1:0]                 chain_evt,
  output logic [NCODE-1:0]                 pend,
  output logic [NCODE-1:0]                 chain_trig,
  output logic                             irq
);
  logic                             ready_q;
  logic [NUM_PORTS-1:0][NCODE-1:0]  port_chain;
  logic [NUM_PORTS-1:0][NCODE-1:0]  port_irq;
  logic [NCODE-1:0]                 chain_any;
  logic [NCODE-1:0]                 irq_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign cmpl_ready = {NUM_PORTS{ready_q}};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    xfer_done_decode #(.CODE_W(CODE_W)) u_dec (
      .take      (cmpl_valid[p] & ready_q),
      .code      (cmpl_code[p]),
      .is_final  (cmpl_final[p]),
      .en        (done_en_t'(cmpl_en[p])),
      .chain_set (port_chain[p]),
      .irq_set   (port_irq[p])
    );
  end

  always_comb begin
    chain_any = '0;
    irq_any   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      chain_any = chain_any | port_chain[p];
      irq_any   = irq_any   | port_irq[p];
    end
  end

  xfer_done_bitreg #(.W(NCODE)) u_chain_reg (
    .clk(clk), .rst_n(rst_n), .set_bits(chain_any),
    .clr_we(clr_chain_we), .clr_bits(clr_chain_bits), .q(chain_evt)
  );

  xfer_done_bitreg #(.W(NCODE)) u_pend_reg (
    .clk(clk), .rst_n(rst_n), .set_bits(irq_any),
    .clr_we(clr_pend_we), .clr_bits(clr_pend_bits), .q(pend)
  );

  xfer_done_pulse #(.W(NCODE)) u_trig (
    .clk(clk), .rst_n(rst_n), .set_bits(chain_any), .trig(chain_trig)
  );

  assign irq = |(pend & irq_mask);
endmodule

// File: rtl/xfer_done_events_chk.sv
module xfer_done_events_chk #(
  parameter int NUM_PORTS = 2,
  parameter int CODE_W    = 6,
  parameter int EN_W      = 4,
  localparam int NCODE    = 1 << CODE_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PORTS-1:0]             cmpl_valid,
  input logic [NUM_PORTS-1:0]             cmpl_ready,
  input logic [NUM_PORTS-1:0][CODE_W-1:0] cmpl_code,
  input logic [NUM_PORTS-1:0]             cmpl_final,
  input logic [NUM_PORTS-1:0][EN_W-1:0]   cmpl_en,
  input logic                             clr_pend_we,
  input logic [NCODE-1:0]                 clr_pend_bits,
  input logic [NCODE-1:0]                 irq_mask,
  input logic [NCODE-1:0]                 chain_evt,
  input logic [NCODE-1:0]                 pend,
  input logic [NCODE-1:0]                 chain_trig,
  input logic                             irq
);
  // R1
  final_chain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid[0] && cmpl_ready[0] && cmpl_final[0] && cmpl_en[0][0]
    |=> chain_evt[$past(cmpl_code[0])]);

  // R2
  final_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid[0] && cmpl_ready[0] && cmpl_final[0] && cmpl_en[0][2]
    |=> pend[$past(cmpl_code[0])]);

  // R3
  inter_chain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid[0] && cmpl_ready[0] && !cmpl_final[0] && cmpl_en[0][1]
    |=> chain_evt[$past(cmpl_code[0])]);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid[0] && cmpl_ready[0] && cmpl_final[0] && cmpl_en[0][2]
    && clr_pend_we && clr_pend_bits[cmpl_code[0]]
    |=> pend[$past(cmpl_code[0])]);

  // R11
  pend_rise_needs_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> $past(|cmpl_valid));

  // R9
  trig_needs_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_trig != '0) |-> $past(|cmpl_valid));

  // R9
  trig_within_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_trig & ~chain_evt) == '0);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & irq_mask) == '0) |-> !irq);

  // R10
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (&cmpl_ready));
endmodule

bind xfer_done_events xfer_done_events_chk #(
  .NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W), .EN_W(xfer_done_pkg::EN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_ready(cmpl_ready),
  .cmpl_code(cmpl_code), .cmpl_final(cmpl_final), .cmpl_en(cmpl_en),
  .clr_pend_we(clr_pend_we), .clr_pend_bits(clr_pend_bits), .irq_mask(irq_mask),
  .chain_evt(chain_evt), .pend(pend), .chain_trig(chain_trig), .irq(irq)
);

// File: tb/xfer_done_events_bench.sv
module xfer_done_events_bench;
  localparam int P  = 2;
  localparam int CW = 6;
  localparam int N  = 1 << CW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [P-1:0]         cmpl_valid = '0;
  logic [P-1:0]         cmpl_ready;
  logic [P-1:0][CW-1:0] cmpl_code = '0;
  logic [P-1:0]         cmpl_final = '0;
  logic [P-1:0][3:0]    cmpl_en = '0;
  logic                 clr_chain_we = 1'b0;
  logic [N-1:0]         clr_chain_bits = '0;
  logic                 clr_pend_we = 1'b0;
  logic [N-1:0]         clr_pend_bits = '0;
  logic [N-1:0]         irq_mask = '0;
  logic [N-1:0]         chain_evt, pend, chain_trig;
  logic                 irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xfer_done_events #(.NUM_PORTS(P), .CODE_W(CW)) u_xfer_done_events (.*);

  // {code, final, en[3:0], exp_chain, exp_pend}
  localparam int VW = 13;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'd5,  1'b1, 4'b0001, 1'b1, 1'b0},  // R1
    {6'd5,  1'b0, 4'b0001, 1'b0, 1'b0},  // R1
    {6'd63, 1'b1, 4'b0100, 1'b0, 1'b1},  // R2
    {6'd0,  1'b0, 4'b0100, 1'b0, 1'b0},  // R2
    {6'd17, 1'b0, 4'b0010, 1'b1, 1'b0},  // R3
    {6'd17, 1'b1, 4'b0010, 1'b0, 1'b0},  // R3
    {6'd40, 1'b0, 4'b1000, 1'b0, 1'b1},  // R3
    {6'd40, 1'b1, 4'b1010, 1'b0, 1'b0},  // R3
    {6'd9,  1'b0, 4'b0011, 1'b1, 1'b0},  // R4
    {6'd9,  1'b1, 4'b0011, 1'b1, 1'b0},  // R4
    {6'd33, 1'b1, 4'b1100, 1'b0, 1'b1},  // R4
    {6'd33, 1'b0, 4'b1111, 1'b1, 1'b1},  // R4
    {6'd2,  1'b1, 4'b0101, 1'b1, 1'b1}   // R1 R2
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] bitv(input int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic clear_all();
    @(negedge clk);
    cmpl_valid = '0;
    clr_chain_we = 1'b1; clr_chain_bits = '1;
    clr_pend_we  = 1'b1; clr_pend_bits  = '1;
    @(negedge clk);
    clr_chain_we = 1'b0; clr_chain_bits = '0;
    clr_pend_we  = 1'b0; clr_pend_bits  = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 chain", chain_evt, '0);
    chk("R10 pend", pend, '0);
    chk("R10 ready low", N'(cmpl_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready", N'(cmpl_ready), N'({P{1'b1}}));

    // Vector table, port 0
    for (int v = 0; v < NV; v++) begin
      clear_all();
      cmpl_valid[0] = 1'b1;
      cmpl_code[0]  = VEC[v][12:7];
      cmpl_final[0] = VEC[v][6];
      cmpl_en[0]    = VEC[v][5:2];
      @(negedge clk);
      cmpl_valid[0] = 1'b0;
      chk($sformatf("R1-4 v%0d chain", v), chain_evt,  VEC[v][1] ? bitv(int'(VEC[v][12:7])) : '0);
      chk($sformatf("R1-4 v%0d pend", v),  pend,       VEC[v][0] ? bitv(int'(VEC[v][12:7])) : '0);
      chk($sformatf("R9 v%0d trig", v),    chain_trig, VEC[v][1] ? bitv(int'(VEC[v][12:7])) : '0);
    end

    // R11: valid low ignored
    clear_all();
    cmpl_code[0] = 6'd11; cmpl_final[0] = 1'b1; cmpl_en[0] = 4'b1111;
    @(negedge clk);
    chk("R11 chain", chain_evt, '0);
    chk("R11 pend", pend, '0);

    // R5: two ports same cycle
    clear_all();
    cmpl_valid = 2'b11;
    cmpl_code[0] = 6'd3;  cmpl_final[0] = 1'b1; cmpl_en[0] = 4'b0101;
    cmpl_code[1] = 6'd60; cmpl_final[1] = 1'b1; cmpl_en[1] = 4'b0101;
    @(negedge clk);
    cmpl_valid = '0;
    chk("R5 chain", chain_evt, bitv(3) | bitv(60));
    chk("R5 pend", pend, bitv(3) | bitv(60));
    @(negedge clk);
    // R9: trigger lasts one cycle
    chk("R9 trig drop", chain_trig, '0);
    chk("R9 chain held", chain_evt, bitv(3) | bitv(60));

    // R8: irq follows mask
    #1;
    chk("R8 irq masked", N'(irq), '0);
    irq_mask = bitv(60);
    #1;
    chk("R8 irq on", N'(irq), N'(1));
    irq_mask = bitv(7);
    #1;
    chk("R8 irq other", N'(irq), '0);
    irq_mask = '1;

    // R6: selective clear
    @(negedge clk);
    clr_pend_we = 1'b1; clr_pend_bits = bitv(3);
    clr_chain_we = 1'b1; clr_chain_bits = bitv(60);
    @(negedge clk);
    clr_pend_we = 1'b0; clr_chain_we = 1'b0;
    chk("R6 pend", pend, bitv(60));
    chk("R6 chain", chain_evt, bitv(3));

    // R7: set beats clear
    clr_pend_we = 1'b1; clr_pend_bits = '1;
    cmpl_valid[1] = 1'b1; cmpl_code[1] = 6'd44; cmpl_final[1] = 1'b1; cmpl_en[1] = 4'b0100;
    @(negedge clk);
    clr_pend_we = 1'b0; cmpl_valid = '0;
    chk("R7 pend", pend, bitv(44));

    // R5: same code from both ports
    clear_all();
    cmpl_valid = 2'b11;
    cmpl_code[0] = 6'd21; cmpl_final[0] = 1'b0; cmpl_en[0] = 4'b0010;
    cmpl_code[1] = 6'd21; cmpl_final[1] = 1'b1; cmpl_en[1] = 4'b0001;
    @(negedge clk);
    cmpl_valid = '0;
    chk("R5 same code", chain_evt, bitv(21));

    // R10: reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 reset chain", chain_evt, '0);
    chk("R10 reset trig", chain_trig, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule